// File: doc/BRIEF.md
# Aligned Block Cache-Maintenance Expander

This block takes one cache-maintenance command that names a fixed-size memory block and turns it into a stream of per-line requests for a cache controller downstream. The command gives any byte address inside the target block, a two-bit size code, an operation type and a flag that marks the address as virtual or physical. The block clears the low address bits to find the naturally aligned base of the block that holds the address. It then walks upward from that base one cache line at a time. The next line is offered only after the current one has been taken.

An implementation may choose not to support every size. A parameter mask lists the sizes that are supported. A command whose size is reserved, or is left out of the mask, is treated as a hint and dropped: it issues no line requests and finishes at once with an "ignored" status. Every command, performed or dropped, ends with a single-cycle completion pulse and a status bit. Only one command is in flight at a time. The command port is ready only while the block is idle.

Top module: `blkcmo_expander`

## Requirements
- R1: After synchronous reset the block is idle: `cmd_ready` is 1, `req_valid` is 0 and `done` is 0.
- R2: The size code maps as 2'b00 = 64 bytes, 2'b01 = 512 bytes, 2'b10 = 4096 bytes, and 2'b11 is reserved. For an accepted, supported command, the first request carries the command address with its low log2(max(block size, LINE_BYTES)) bits cleared. It appears in the cycle after acceptance.
- R3: Each handshake (`req_valid` and `req_ready` both high at a clock edge) moves `req_addr` up by LINE_BYTES on the following request. While `req_ready` is low, `req_valid` stays high and `req_addr` holds its value.
- R4: A supported command whose block is larger than a line issues exactly block size / LINE_BYTES handshakes. For example, 4096 bytes with 64-byte lines gives 64 handshakes.
- R5: A command with size code 2'b11, or with a size code i whose bit i in SIZE_MASK is 0, issues no requests. `done` is 1 with `done_performed` 0 in the cycle after acceptance.
- R6: After the final handshake of a command, `done` is high for exactly one cycle, in the next cycle, with `done_performed` = 1. No request is valid while `done` is high.
- R7: When the block size is not larger than LINE_BYTES, exactly one request is issued, at the line-aligned address.
- R8: Every request carries on `req_op` and `req_phys` the operation type and the flag (0 = virtual, 1 = physical) captured when the command was accepted.
- R9: `cmd_ready` is 1 only while idle. It is 0 while requests are being issued and in the `done` cycle, so a command held valid during that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_addr | input | ADDR_W | Any address inside the target block |
| cmd_size | input | 2 | Block size code |
| cmd_op | input | OP_W | Maintenance operation type |
| cmd_phys | input | 1 | Address kind: 0 virtual, 1 physical |
| req_valid | output | 1 | Line request offered |
| req_ready | input | 1 | Downstream takes the line request |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_op | output | OP_W | Operation type for this line |
| req_phys | output | 1 | Address kind for this line |
| done | output | 1 | One-cycle completion pulse |
| done_performed | output | 1 | With done: 1 performed, 0 ignored |

## Verification
The bench builds two instances with the same stimulus. One uses the defaults: 64-byte lines and all three sizes enabled. This covers the 1-, 8- and 64-line walks and the reserved code. The second uses 1024-byte lines and a mask that leaves out the 512-byte size. This covers the single-request case where the block is smaller than a line, a 4-line walk of a 4 KB block, and a supported-looking code that is dropped only because of the mask. Back-pressure patterns of always ready, alternating and pseudo-random test the stall-hold and stepping rules. An address at the top of the space tests that the walk does not wrap.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    // largest block the command can name, as log2 of bytes
    localparam int MAX_BLK_LG = 12;

    typedef enum logic [1:0] {
        SZ_64B  = 2'b00,
        SZ_512B = 2'b01,
        SZ_4KB  = 2'b10,
        SZ_RSVD = 2'b11
    } blk_size_e;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'b00,
        WK_ISSUE = 2'b01,
        WK_FIN   = 2'b10
    } walk_state_e;

    // log2 of the block size in bytes; reserved code yields 0
    function automatic int blk_log2(input blk_size_e sz);
        case (sz)
            SZ_64B:  return 6;
            SZ_512B: return 9;
            SZ_4KB:  return 12;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cmo_decode.sv
module cmo_decode #(
    parameter int          ADDR_W     = 32,
    parameter int          LINE_BYTES = 64,
    parameter logic [2:0]  SIZE_MASK  = 3'b111,
    localparam int         LINE_LG    = $clog2(LINE_BYTES),
    localparam int         CNT_W      = cmo_pkg::MAX_BLK_LG - LINE_LG + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  nlines,
    output logic              supported
);
    import cmo_pkg::*;

    int           blk_lg;
    int           eff_lg;
    logic [3:0]   mask4;
    blk_size_e    size_e;

    assign size_e = blk_size_e'(size);
    assign mask4  = {1'b0, SIZE_MASK};

    always_comb begin
        blk_lg    = blk_log2(size_e);
        eff_lg    = (blk_lg > LINE_LG) ? blk_lg : LINE_LG;
        base      = addr & ({ADDR_W{1'b1}} << eff_lg);
        nlines    = CNT_W'(1) << (eff_lg - LINE_LG);
        supported = (size_e != SZ_RSVD) && mask4[size];
    end

endmodule

// File: rtl/cmo_walker.sv
module cmo_walker #(
    parameter int  ADDR_W     = 32,
    parameter int  OP_W       = 3,
    parameter int  LINE_BYTES = 64,
    parameter int  CNT_W      = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_perform,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [CNT_W-1:0]  start_lines,
    input  logic [OP_W-1:0]   start_op,
    input  logic              start_phys,
    output logic              idle,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OP_W-1:0]   req_op,
    output logic              req_phys,
    output logic              done,
    output logic              done_performed
);
    import cmo_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [OP_W-1:0]   op;
        logic              phys;
        logic              perf;
    } walk_ctx_t;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

    walk_state_e st_q, st_d;
    walk_ctx_t   ctx_q, ctx_d;
    logic        take;
    logic        last;

    assign take = (st_q == WK_ISSUE) && req_ready;
    assign last = (ctx_q.left == CNT_W'(1));

    always_comb begin
        st_d  = st_q;
        ctx_d = ctx_q;
        case (st_q)
            WK_IDLE: begin
                if (start) begin
                    ctx_d.op   = start_op;
                    ctx_d.phys = start_phys;
                    ctx_d.perf = start_perform;
                    ctx_d.addr = start_base;
                    ctx_d.left = start_lines;
                    st_d       = start_perform ? WK_ISSUE : WK_FIN;
                end
            end
            WK_ISSUE: begin
                if (take) begin
                    if (last) begin
                        st_d = WK_FIN;
                    end else begin
                        ctx_d.addr = ctx_q.addr + STEP;
                        ctx_d.left = ctx_q.left - CNT_W'(1);
                    end
                end
            end
            default: st_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WK_IDLE;
            ctx_q <= '0;
        end else begin
            st_q  <= st_d;
            ctx_q <= ctx_d;
        end
    end

    assign idle           = (st_q == WK_IDLE);
    assign req_valid      = (st_q == WK_ISSUE);
    assign req_addr       = ctx_q.addr;
    assign req_op         = ctx_q.op;
    assign req_phys       = ctx_q.phys;
    assign done           = (st_q == WK_FIN);
    assign done_performed = done && ctx_q.perf;

    // R3: a stalled request is held with the same address
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R3: after a handshake either the walk ends or the next line follows
    assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> done || (req_valid && req_addr == $past(req_addr) + STEP));

    // R8: attributes stay fixed across the walk
    assert_attr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && $past(req_valid) |-> $stable(req_op) && $stable(req_phys));

    // R6: completion is a single pulse and never overlaps a request
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

endmodule

// File: rtl/blkcmo_expander.sv
module blkcmo_expander #(
    parameter int          ADDR_W     = 32,
    parameter int          OP_W       = 3,
    parameter int          LINE_BYTES = 64,
    parameter logic [2:0]  SIZE_MASK  = 3'b111,
    localparam int         LINE_LG    = $clog2(LINE_BYTES),
    localparam int         CNT_W      = cmo_pkg::MAX_BLK_LG - LINE_LG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_size,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic              cmd_phys,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OP_W-1:0]   req_op,
    output logic              req_phys,
    output logic              done,
    output logic              done_performed
);
    logic [ADDR_W-1:0] dec_base;
    logic [CNT_W-1:0]  dec_lines;
    logic              dec_ok;
    logic              accept;
    logic              idle;

    cmo_decode #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .SIZE_MASK  (SIZE_MASK)
    ) u_decode (
        .addr      (cmd_addr),
        .size      (cmd_size),
        .base      (dec_base),
        .nlines    (dec_lines),
        .supported (dec_ok)
    );

    assign cmd_ready = idle;
    assign accept    = cmd_valid && idle;

    cmo_walker #(
        .ADDR_W     (ADDR_W),
        .OP_W       (OP_W),
        .LINE_BYTES (LINE_BYTES),
        .CNT_W      (CNT_W)
    ) u_walker (
        .clk            (clk),
        .rst            (rst),
        .start          (accept),
        .start_perform  (dec_ok),
        .start_base     (dec_base),
        .start_lines    (dec_lines),
        .start_op       (cmd_op),
        .start_phys     (cmd_phys),
        .idle           (idle),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_op         (req_op),
        .req_phys       (req_phys),
        .done           (done),
        .done_performed (done_performed)
    );

    // R5: a dropped command completes next cycle as ignored
    assert_drop_done_R5: assert property (@(posedge clk) disable iff (rst)
        accept && !dec_ok |=> done && !done_performed && !req_valid);

    // R2: first request is the aligned base with the captured attributes (R8)
    assert_first_req_R2: assert property (@(posedge clk) disable iff (rst)
        accept && dec_ok |=> req_valid && req_addr == $past(dec_base)
                             && req_op == $past(cmd_op) && req_phys == $past(cmd_phys));

    // R9: no command is taken while requests are outstanding
    assert_busy_block_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid || done) |-> !cmd_ready);

endmodule

// File: tb/tb_blkcmo_expander.sv
module tb_cmo_model #(
    parameter int          LINE_BYTES = 64,
    parameter logic [2:0]  SIZE_MASK  = 3'b111
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_addr,
    input  logic [1:0]  cmd_size,
    input  logic [2:0]  cmd_op,
    input  logic        cmd_phys,
    input  logic        req_ready,
    output logic        e_ready,
    output logic        e_valid,
    output logic [31:0] e_addr,
    output logic [2:0]  e_op,
    output logic        e_phys,
    output logic        e_done,
    output logic        e_perf
);
    int     state = 0;
    longint cur = 0;
    int     left = 0;
    logic   perf = 0;
    logic [2:0] op_l = 0;
    logic   ph_l = 0;

    always @(posedge clk) begin
        if (rst) begin
            state = 0;
        end else begin
            case (state)
                0: if (cmd_valid) begin
                    longint bytes, eff;
                    bytes = 64 << (3 * cmd_size);
                    if (cmd_size != 2'd3 && SIZE_MASK[cmd_size]) begin
                        eff   = (bytes > LINE_BYTES) ? bytes : LINE_BYTES;
                        cur   = (longint'(cmd_addr) / eff) * eff;
                        left  = int'(eff / LINE_BYTES);
                        perf  = 1;
                        op_l  = cmd_op;
                        ph_l  = cmd_phys;
                        state = 1;
                    end else begin
                        perf  = 0;
                        state = 2;
                    end
                end
                1: if (req_ready) begin
                    if (left == 1) state = 2;
                    else begin
                        cur  = cur + LINE_BYTES;
                        left = left - 1;
                    end
                end
                default: state = 0;
            endcase
        end
    end

    always_comb begin
        e_ready = (state == 0);
        e_valid = (state == 1);
        e_addr  = cur[31:0];
        e_op    = op_l;
        e_phys  = ph_l;
        e_done  = (state == 2);
        e_perf  = (state == 2) && perf;
    end
endmodule

module tb_blkcmo_expander;
    localparam int CLK_PERIOD = 10;
    localparam int WIDE_LINE  = 1024;
    localparam logic [2:0] WIDE_MASK = 3'b101;

    logic clk = 0;
    logic rst = 1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        va = 0, vb = 0;
    logic [31:0] c_addr = 0;
    logic [1:0]  c_size = 0;
    logic [2:0]  c_op = 0;
    logic        c_phys = 0;
    logic        rr = 1;
    int          rmode = 0;

    logic        rdy_a, val_a, dn_a, pf_a, ph_a;
    logic [31:0] ad_a;
    logic [2:0]  op_a;
    logic        rdy_b, val_b, dn_b, pf_b, ph_b;
    logic [31:0] ad_b;
    logic [2:0]  op_b;

    logic        x_rdy_a, x_val_a, x_dn_a, x_pf_a, x_ph_a;
    logic [31:0] x_ad_a;
    logic [2:0]  x_op_a;
    logic        x_rdy_b, x_val_b, x_dn_b, x_pf_b, x_ph_b;
    logic [31:0] x_ad_b;
    logic [2:0]  x_op_b;

    blkcmo_expander dut (
        .clk(clk), .rst(rst), .cmd_valid(va), .cmd_ready(rdy_a),
        .cmd_addr(c_addr), .cmd_size(c_size), .cmd_op(c_op), .cmd_phys(c_phys),
        .req_valid(val_a), .req_ready(rr), .req_addr(ad_a), .req_op(op_a),
        .req_phys(ph_a), .done(dn_a), .done_performed(pf_a));

    blkcmo_expander #(.LINE_BYTES(WIDE_LINE), .SIZE_MASK(WIDE_MASK)) dut_wide (
        .clk(clk), .rst(rst), .cmd_valid(vb), .cmd_ready(rdy_b),
        .cmd_addr(c_addr), .cmd_size(c_size), .cmd_op(c_op), .cmd_phys(c_phys),
        .req_valid(val_b), .req_ready(rr), .req_addr(ad_b), .req_op(op_b),
        .req_phys(ph_b), .done(dn_b), .done_performed(pf_b));

    tb_cmo_model m_a (
        .clk(clk), .rst(rst), .cmd_valid(va), .cmd_addr(c_addr), .cmd_size(c_size),
        .cmd_op(c_op), .cmd_phys(c_phys), .req_ready(rr),
        .e_ready(x_rdy_a), .e_valid(x_val_a), .e_addr(x_ad_a), .e_op(x_op_a),
        .e_phys(x_ph_a), .e_done(x_dn_a), .e_perf(x_pf_a));

    tb_cmo_model #(.LINE_BYTES(WIDE_LINE), .SIZE_MASK(WIDE_MASK)) m_b (
        .clk(clk), .rst(rst), .cmd_valid(vb), .cmd_addr(c_addr), .cmd_size(c_size),
        .cmd_op(c_op), .cmd_phys(c_phys), .req_ready(rr),
        .e_ready(x_rdy_b), .e_valid(x_val_b), .e_addr(x_ad_b), .e_op(x_op_b),
        .e_phys(x_ph_b), .e_done(x_dn_b), .e_perf(x_pf_b));

    int checks = 0;
    int fails = 0;
    bit started = 0;
    int cnt_a = 0, cnt_b = 0, want_a = 0, want_b = 0;
    int dones_a = 0, dones_b = 0, cmds = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int lines_for(input logic [1:0] sz, input int line, input logic [2:0] mask);
        int bytes;
        bytes = 64 << (3 * sz);
        if (sz == 2'd3 || !mask[sz]) return 0;
        return (bytes > line) ? bytes / line : 1;
    endfunction

    function automatic string cnt_tag(input int n, input logic [1:0] sz, input int line);
        if (n == 0) return "R5";
        if ((64 << (3 * sz)) <= line) return "R7";
        return "R4";
    endfunction

    // per-cycle comparison against the reference model, away from the edge
    always @(negedge clk) begin
        if (started) begin
            chk(rdy_a == x_rdy_a, "R9", "A cmd_ready", rdy_a, x_rdy_a);
            chk(val_a == x_val_a, "R3", "A req_valid", val_a, x_val_a);
            chk(dn_a == x_dn_a, "R6", "A done", dn_a, x_dn_a);
            chk(pf_a == x_pf_a, "R5 R6", "A done_performed", pf_a, x_pf_a);
            if (x_val_a) begin
                chk(ad_a == x_ad_a, "R2 R3", "A req_addr", ad_a, x_ad_a);
                chk(op_a == x_op_a && ph_a == x_ph_a, "R8", "A op/phys",
                    {op_a, ph_a}, {x_op_a, x_ph_a});
            end
            chk(rdy_b == x_rdy_b, "R9", "B cmd_ready", rdy_b, x_rdy_b);
            chk(val_b == x_val_b, "R3", "B req_valid", val_b, x_val_b);
            chk(dn_b == x_dn_b, "R6", "B done", dn_b, x_dn_b);
            chk(pf_b == x_pf_b, "R5 R6", "B done_performed", pf_b, x_pf_b);
            if (x_val_b) begin
                chk(ad_b == x_ad_b, "R2 R3", "B req_addr", ad_b, x_ad_b);
                chk(op_b == x_op_b && ph_b == x_ph_b, "R8", "B op/phys",
                    {op_b, ph_b}, {x_op_b, x_ph_b});
            end
            if (!rst) begin
                if (va && rdy_a) begin
                    cnt_a = 0;
                    want_a = lines_for(c_size, 64, 3'b111);
                end
                if (vb && rdy_b) begin
                    cnt_b = 0;
                    want_b = lines_for(c_size, WIDE_LINE, WIDE_MASK);
                end
                if (val_a && rr) cnt_a++;
                if (val_b && rr) cnt_b++;
                if (dn_a) begin
                    dones_a++;
                    chk(cnt_a == want_a, cnt_tag(want_a, c_size, 64), "A line count", cnt_a, want_a);
                end
                if (dn_b) begin
                    dones_b++;
                    chk(cnt_b == want_b, cnt_tag(want_b, c_size, WIDE_LINE), "B line count", cnt_b, want_b);
                end
            end
        end
    end

    // downstream back-pressure patterns
    initial begin
        logic [7:0] lf = 8'h5a;
        forever begin
            @(posedge clk);
            #1;
            case (rmode)
                0: rr = 1;
                1: rr = ~rr;
                default: begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    rr = lf[0];
                end
            endcase
        end
    end

    task automatic issue(input logic [31:0] a, input logic [1:0] s,
                         input logic [2:0] o, input logic p);
        bit ga, gb;
        @(posedge clk);
        #1;
        c_addr = a; c_size = s; c_op = o; c_phys = p;
        va = 1; vb = 1;
        cmds++;
        while (va || vb) begin
            @(negedge clk);
            ga = va && rdy_a;
            gb = vb && rdy_b;
            @(posedge clk);
            #1;
            if (ga) va = 0;
            if (gb) vb = 0;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-reqs actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        started = 1;
        @(negedge clk);
        // R1: idle outputs while reset is held
        chk(rdy_a && !val_a && !dn_a, "R1", "A reset state", {rdy_a, val_a, dn_a}, 3'b100);
        chk(rdy_b && !val_b && !dn_b, "R1", "B reset state", {rdy_b, val_b, dn_b}, 3'b100);
        @(posedge clk);
        #1;
        rst = 0;

        rmode = 0;
        issue(32'h1234_5ABC, 2'b10, 3'd3, 1'b1);   // 4 KB walk, R4
        issue(32'h0000_0FFF, 2'b00, 3'd1, 1'b0);   // 64 B, one line; R7 on wide
        rmode = 1;
        issue(32'h8000_01C7, 2'b01, 3'd5, 1'b1);   // 512 B; masked off on wide, R5
        issue(32'h4444_4444, 2'b11, 3'd2, 1'b0);   // reserved code, R5
        rmode = 2;
        issue(32'hFFFF_FFFF, 2'b10, 3'd6, 1'b1);   // top of address space
        issue(32'h0000_0040, 2'b00, 3'd7, 1'b1);
        issue(32'h7654_3210, 2'b01, 3'd0, 1'b0);
        rmode = 0;
        issue(32'h0000_0000, 2'b10, 3'd4, 1'b0);

        repeat (200) @(posedge clk);
        #1;
        @(negedge clk);
        chk(dones_a == cmds, "R6", "A completions", dones_a, cmds);
        chk(dones_b == cmds, "R6", "B completions", dones_b, cmds);
        summary();
    end
endmodule